// File: doc/BRIEF.md
# Network Controller Register Front End with Management Shim

This block is the programmed-I/O face of an Ethernet controller. A host reaches a 256-byte window of 16-bit registers through a simple one-access-per-cycle bus that carries byte, word and doubleword transfers. The block holds the interrupt status and enable words and drives one level-sensitive interrupt from them. It keeps receive and transmit packet counters that clear when read, and a control word whose reset bit completes at once. It also offers a PHY management command word whose operations complete against a local 32-entry PHY register bank, with no serial management wire behind it.

The DMA engines sit outside the block. They report finished frames through two single-cycle event pulses, one for receive and one for transmit. Each pulse sets its status bit and bumps its counter. Software starts a PHY access by writing the command word. It then polls that word twice, because the busy bits stay set for the first read after a command. Read data comes back from the local bank, or as all ones when the addressed PHY does not exist. A free-running delay after reset marks the PHY link as up.

Top module: `macreg_front`

## Requirements
- R1: Read data appears on `bus_rdata` one clock after the access. A byte read returns the addressed byte in bits 7:0, and byte address bit 0 selects the high byte. A word read returns bits 15:0. A doubleword read returns the word at the address in bits 15:0 and the word at address+2 in bits 31:16. A doubleword write stores bits 15:0 at the address and bits 31:16 at address+2. Size codes are 0 for byte, 1 for word and 2 for doubleword. Address bit 0 is ignored for word and doubleword accesses.
- R2: A byte write is merged into the other byte of its containing word first. The merged word then goes through the same rules as a word write.
- R3: The interrupt status word at 0x3C ignores writes. A read returns its current value and clears it to zero. A receive event sets bit 0 and a transmit event sets bit 4, and an event in the same cycle as a read takes effect after the clear.
- R4: `irq_o` is recomputed as the OR of (status AND enable at 0x40) only in cycles that write the enable word or carry an event. In every other cycle it holds its value, which includes a read that clears the status.
- R5: The receive counter at 0x50 and the transmit counter at 0x5C count events and ignore writes. A read returns the count and clears it. An event in the same cycle as the read leaves the counter at 1.
- R6: A write of the control word at 0x04 with bit 0 set stores 0x0010. Any other write stores the value as written.
- R7: In the PHY command word at 0x20, bits 12:8 select the PHY and bits 4:0 select its register. Bit 13 requests a read, which loads 0x24 with the bank entry when the PHY is 1 and with 0xFFFF otherwise. A read request takes priority over bit 14.
- R8: A command with bit 14 set and bit 13 clear copies the word at 0x28 into the bank entry when the PHY is 1. For any other PHY the write is discarded.
- R9: After any write of the command word, bits 14:13 of that word are 11. The first read after the command returns them set and then clears them, so the second read returns 00.
- R10: After reset the word at 0x88 holds 0x9F07 and all other words hold 0. PHY registers 1, 2 and 3 hold 0x7869, 0x0243 and 0x0C54, the other PHY registers hold 0, and `irq_o` is low.
- R11: Bit 2 of PHY register 1 becomes set on the LINK_DELAY-th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data, placed as the read data would be |
| bus_rdata | output | 32 | Registered read data |
| rx_evt | input | 1 | Receive-complete pulse |
| tx_evt | input | 1 | Transmit-complete pulse |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The properties assume at most one access per cycle. They also assume that the word accesses they watch use even addresses, and that the event pulses are single-cycle and need no acknowledgement. The status and interrupt properties only reason about cycles with no event pulse, so an event that lands on a status access is left to the reference model rather than to the properties. The stimulus keeps word and doubleword addresses even and mixes fixed scenarios with seeded random traffic over the special words. That traffic includes events that coincide with counter and status reads, and PHY commands aimed at present and absent PHY addresses.

// File: rtl/macreg_pkg.sv
package macreg_pkg;
  localparam int unsigned WIN_BYTES = 256;
  localparam int unsigned WORDS     = WIN_BYTES / 2;
  localparam int unsigned ADDR_W    = $clog2(WIN_BYTES);
  localparam int unsigned IDX_W     = ADDR_W - 1;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  // word indices (byte offset / 2)
  localparam logic [IDX_W-1:0] IDX_CTRL1     = 7'h02;
  localparam logic [IDX_W-1:0] IDX_MDIO_CTRL = 7'h10;
  localparam logic [IDX_W-1:0] IDX_MDIO_RD   = 7'h12;
  localparam logic [IDX_W-1:0] IDX_MDIO_WR   = 7'h14;
  localparam logic [IDX_W-1:0] IDX_STATUS    = 7'h1E;
  localparam logic [IDX_W-1:0] IDX_IEN       = 7'h20;
  localparam logic [IDX_W-1:0] IDX_RXCNT     = 7'h28;
  localparam logic [IDX_W-1:0] IDX_TXCNT     = 7'h2E;
  localparam logic [IDX_W-1:0] IDX_PHYSTAT   = 7'h44;

  localparam logic [15:0] CTRL1_DONE   = 16'h0010;
  localparam logic [15:0] PHYSTAT_INIT = 16'h9F07;
  localparam logic [15:0] MDIO_BUSY    = 16'h6000;
  localparam int unsigned MDIO_RD_BIT  = 13;
  localparam int unsigned MDIO_WR_BIT  = 14;
  localparam logic [4:0]  PHY_PRESENT  = 5'd1;
  localparam int unsigned RX_BIT       = 0;
  localparam int unsigned TX_BIT       = 4;

  localparam int unsigned LINK_BIT     = 2;
  localparam logic [15:0] PHY_R1_INIT  = 16'h786D & ~(16'h0001 << LINK_BIT);
  localparam logic [15:0] PHY_R2_INIT  = 16'h0243;
  localparam logic [15:0] PHY_R3_INIT  = 16'h0C54;
endpackage

// File: rtl/macreg_event_ctr.sv
module macreg_event_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i || inc_i) begin
      cnt_q <= (clr_i ? '0 : cnt_q) + CNT_W'(inc_i);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/macreg_phy_bank.sv
module macreg_phy_bank
  import macreg_pkg::*;
#(
  parameter int unsigned PHY_REGS   = 32,
  parameter int unsigned LINK_DELAY = 1000,
  localparam int unsigned AW = $clog2(PHY_REGS),
  localparam int unsigned CW = $clog2(LINK_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata
);
  logic [15:0]   mem [PHY_REGS];
  logic [CW-1:0] dly_q;
  logic          fire;

  assign fire  = (dly_q == CW'(LINK_DELAY - 1));
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHY_REGS; i++) mem[i] <= '0;
      mem[1] <= PHY_R1_INIT;
      mem[2] <= PHY_R2_INIT;
      mem[3] <= PHY_R3_INIT;
      dly_q  <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (dly_q != CW'(LINK_DELAY)) dly_q <= dly_q + 1'b1;
      if (fire) mem[1][LINK_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/macreg_front.sv
module macreg_front
  import macreg_pkg::*;
#(
  parameter int unsigned LINK_DELAY = 1000,
  parameter int unsigned PHY_REGS   = 32,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned PHY_AW = $clog2(PHY_REGS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_size,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_evt,
  input  logic        tx_evt,
  output logic        irq_o
);
  logic [15:0] regs_q [WORDS];
  logic [15:0] regs_d [WORDS];
  logic        pend_q, pend_d;
  logic        irq_q, irq_d;
  logic [31:0] rdata_q, rdata_d;
  logic        en_written;

  logic [IDX_W-1:0] lane_idx    [2];
  logic             lane_wr     [2];
  logic             lane_rd     [2];
  logic [15:0]      lane_old    [2];
  logic [15:0]      lane_merged [2];
  logic [15:0]      lane_rval   [2];

  logic [CNT_W-1:0] ctr_val [2];
  logic [15:0]      ctr_ext [2];
  logic             ctr_clr [2];

  // ---------------- access lanes ----------------
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic        act;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] mask;
    assign act  = bus_valid && ((l == 0) || (bus_size == SZ_DWORD));
    assign lane_idx[l] = bus_addr[ADDR_W-1:1] + IDX_W'(l);
    assign lane_wr[l]  = act && bus_write;
    assign lane_rd[l]  = act && !bus_write;
    assign be   = (bus_size == SZ_BYTE) ? (bus_addr[0] ? 2'b10 : 2'b01) : 2'b11;
    assign wd   = (l == 1) ? bus_wdata[31:16]
                : (bus_size == SZ_BYTE) ? {bus_wdata[7:0], bus_wdata[7:0]}
                : bus_wdata[15:0];
    assign mask = {{8{be[1]}}, {8{be[0]}}};
    assign lane_old[l]    = regs_q[lane_idx[l]];
    assign lane_merged[l] = (lane_old[l] & ~mask) | (wd & mask);
    assign lane_rval[l]   = (lane_idx[l] == IDX_RXCNT) ? ctr_ext[0]
                          : (lane_idx[l] == IDX_TXCNT) ? ctr_ext[1]
                          : lane_old[l];
  end

  // ---------------- packet counters ----------------
  for (genvar k = 0; k < 2; k++) begin : g_ctr
    localparam logic [IDX_W-1:0] CIDX = (k == 0) ? IDX_RXCNT : IDX_TXCNT;
    assign ctr_clr[k] = (lane_rd[0] && lane_idx[0] == CIDX) ||
                        (lane_rd[1] && lane_idx[1] == CIDX);
    assign ctr_ext[k] = 16'(ctr_val[k]);
    macreg_event_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .inc_i ((k == 0) ? rx_evt : tx_evt),
      .clr_i (ctr_clr[k]),
      .cnt_o (ctr_val[k])
    );
  end

  // ---------------- PHY management shim ----------------
  logic [15:0] mdio_cmd;
  logic        mdio_present;
  logic [15:0] bank_rdata;
  logic        bank_we;

  assign mdio_cmd     = (lane_wr[0] && lane_idx[0] == IDX_MDIO_CTRL) ? lane_merged[0]
                                                                      : lane_merged[1];
  assign mdio_present = (mdio_cmd[12:8] == PHY_PRESENT);

  macreg_phy_bank #(.PHY_REGS(PHY_REGS), .LINK_DELAY(LINK_DELAY)) u_phy (
    .clk   (clk),
    .rst   (rst),
    .raddr (mdio_cmd[PHY_AW-1:0]),
    .rdata (bank_rdata),
    .we    (bank_we),
    .waddr (mdio_cmd[PHY_AW-1:0]),
    .wdata (regs_q[IDX_MDIO_WR])
  );

  // ---------------- next-state of the word file ----------------
  always_comb begin
    regs_d     = regs_q;
    pend_d     = pend_q;
    en_written = 1'b0;
    bank_we    = 1'b0;
    for (int l = 0; l < 2; l++) begin
      if (lane_wr[l]) begin
        case (lane_idx[l])
          IDX_STATUS, IDX_RXCNT, IDX_TXCNT: ;
          IDX_CTRL1:
            regs_d[lane_idx[l]] = lane_merged[l][0] ? CTRL1_DONE : lane_merged[l];
          IDX_MDIO_CTRL: begin
            regs_d[lane_idx[l]] = lane_merged[l] | MDIO_BUSY;
            pend_d = 1'b1;
            if (lane_merged[l][MDIO_RD_BIT])
              regs_d[IDX_MDIO_RD] = mdio_present ? bank_rdata : 16'hFFFF;
            else if (lane_merged[l][MDIO_WR_BIT])
              bank_we = mdio_present;
          end
          IDX_IEN: begin
            regs_d[lane_idx[l]] = lane_merged[l];
            en_written = 1'b1;
          end
          default: regs_d[lane_idx[l]] = lane_merged[l];
        endcase
      end else if (lane_rd[l]) begin
        if (lane_idx[l] == IDX_STATUS) regs_d[IDX_STATUS] = '0;
        if (lane_idx[l] == IDX_MDIO_CTRL && pend_q) begin
          regs_d[IDX_MDIO_CTRL] = regs_q[IDX_MDIO_CTRL] & ~MDIO_BUSY;
          pend_d = 1'b0;
        end
      end
    end
    regs_d[IDX_STATUS][RX_BIT] = regs_d[IDX_STATUS][RX_BIT] | rx_evt;
    regs_d[IDX_STATUS][TX_BIT] = regs_d[IDX_STATUS][TX_BIT] | tx_evt;
    irq_d = (en_written || rx_evt || tx_evt) ? |(regs_d[IDX_STATUS] & regs_d[IDX_IEN])
                                             : irq_q;
  end

  // ---------------- read data ----------------
  always_comb begin
    rdata_d = rdata_q;
    if (bus_valid && !bus_write) begin
      case (bus_size)
        SZ_BYTE:  rdata_d = {24'd0, bus_addr[0] ? lane_rval[0][15:8] : lane_rval[0][7:0]};
        SZ_DWORD: rdata_d = {lane_rval[1], lane_rval[0]};
        default:  rdata_d = {16'd0, lane_rval[0]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) regs_q[w] <= '0;
      regs_q[IDX_PHYSTAT] <= PHYSTAT_INIT;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      regs_q  <= regs_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/macreg_front_chk.sv
module macreg_front_chk
  import macreg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [1:0]  bus_size,
  input logic [7:0]  bus_addr,
  input logic        wd0,
  input logic        rx_evt,
  input logic        tx_evt,
  input logic        irq_o,
  input logic        en_wr,
  input logic        mdio_pend,
  input logic [15:0] ctrl1_w,
  input logic [15:0] mdio_ctrl_w,
  input logic [15:0] status_w
);
  logic word_acc, no_evt;
  assign word_acc = bus_valid && (bus_size == SZ_WORD);
  assign no_evt   = !rx_evt && !tx_evt;

  AST_CTRL1_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    word_acc && bus_write && bus_addr == 8'h04 && wd0 |=> ctrl1_w == CTRL1_DONE); // R6
  AST_MDIO_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    word_acc && bus_write && bus_addr == 8'h20 |=> mdio_pend && mdio_ctrl_w[14:13] == 2'b11); // R9
  AST_MDIO_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
    word_acc && !bus_write && bus_addr == 8'h20 && mdio_pend |=> !mdio_pend && mdio_ctrl_w[14:13] == 2'b00); // R9
  AST_STATUS_NOWR: assert property (@(posedge clk) disable iff (rst)
    word_acc && bus_write && bus_addr == 8'h3C && no_evt |=> $stable(status_w)); // R3
  AST_STATUS_RTC: assert property (@(posedge clk) disable iff (rst)
    word_acc && !bus_write && bus_addr == 8'h3C && no_evt |=> status_w == 16'h0000); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_wr && no_evt |=> $stable(irq_o)); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(en_wr || rx_evt || tx_evt)); // R4
endmodule

bind macreg_front macreg_front_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_size    (bus_size),
  .bus_addr    (bus_addr),
  .wd0         (bus_wdata[0]),
  .rx_evt      (rx_evt),
  .tx_evt      (tx_evt),
  .irq_o       (irq_o),
  .en_wr       (en_written),
  .mdio_pend   (pend_q),
  .ctrl1_w     (regs_q[macreg_pkg::IDX_CTRL1]),
  .mdio_ctrl_w (regs_q[macreg_pkg::IDX_MDIO_CTRL]),
  .status_w    (regs_q[macreg_pkg::IDX_STATUS])
);

// File: tb/macreg_front_bench.sv
module macreg_front_bench;
  localparam int LINK = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_evt = 1'b0, tx_evt = 1'b0;
  logic        irq_o;

  always #4 clk = ~clk;

  macreg_front #(.LINK_DELAY(LINK)) u_macreg_front (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_evt(rx_evt), .tx_evt(tx_evt), .irq_o(irq_o));

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  logic [15:0] m_reg [128];
  logic [15:0] m_phy [32];
  logic        m_pend, m_irq, m_en_wr;
  int          m_rxc, m_txc;
  logic        rd_pend;
  logic [31:0] exp_rdata, last_rd;
  string       cur_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(int idx);
    logic [15:0] v;
    if (idx == 'h28) begin v = 16'(m_rxc); m_rxc = 0; end
    else if (idx == 'h2E) begin v = 16'(m_txc); m_txc = 0; end
    else v = m_reg[idx];
    if (idx == 'h1E) m_reg[idx] = 0;
    if (idx == 'h10 && m_pend) begin m_reg[idx] &= ~16'h6000; m_pend = 0; end
    return v;
  endfunction

  function automatic void m_write(int idx, logic [15:0] v);
    case (idx)
      'h1E, 'h28, 'h2E: ;
      'h02: m_reg[idx] = v[0] ? 16'h0010 : v;
      'h10: begin
        if (v[13]) m_reg['h12] = (v[12:8] == 1) ? m_phy[v[4:0]] : 16'hFFFF;
        else if (v[14] && v[12:8] == 1) m_phy[v[4:0]] = m_reg['h14];
        m_reg[idx] = v | 16'h6000;
        m_pend = 1;
      end
      'h20: begin m_reg[idx] = v; m_en_wr = 1; end
      default: m_reg[idx] = v;
    endcase
  endfunction

  function automatic void model_edge();
    logic [15:0] rv [2];
    m_en_wr = 0;
    rd_pend = 0;
    if (bus_valid) begin
      for (int l = 0; l < ((bus_size == 2) ? 2 : 1); l++) begin
        int idx = (int'(bus_addr[7:1]) + l) % 128;
        if (bus_write) begin
          logic [15:0] d, mask;
          d = (l == 1) ? bus_wdata[31:16] :
              (bus_size == 0) ? {bus_wdata[7:0], bus_wdata[7:0]} : bus_wdata[15:0];
          mask = (bus_size != 0) ? 16'hFFFF : (bus_addr[0] ? 16'hFF00 : 16'h00FF);
          m_write(idx, (m_reg[idx] & ~mask) | (d & mask));
        end else begin
          rv[l] = m_read(idx);
        end
      end
      if (!bus_write) begin
        rd_pend = 1;
        if (bus_size == 0) exp_rdata = {24'd0, bus_addr[0] ? rv[0][15:8] : rv[0][7:0]};
        else if (bus_size == 2) exp_rdata = {rv[1], rv[0]};
        else exp_rdata = {16'd0, rv[0]};
      end
    end
    if (rx_evt) begin m_rxc++; m_reg['h1E][0] = 1'b1; end
    if (tx_evt) begin m_txc++; m_reg['h1E][4] = 1'b1; end
    if (m_en_wr || rx_evt || tx_evt) m_irq = |(m_reg['h1E] & m_reg['h20]);
    cyc++;
    if (cyc == LINK) m_phy[1][2] = 1'b1;
  endfunction

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 irq level", {31'd0, irq_o}, {31'd0, m_irq});
    if (rd_pend) begin
      chk({cur_tag, " read vs model"}, bus_rdata, exp_rdata);
      last_rd = bus_rdata;
    end
    bus_valid = 0; bus_write = 0; rx_evt = 0; tx_evt = 0;
  endtask

  task automatic wr(int sz, int a, logic [31:0] d, string tag);
    bus_valid = 1; bus_write = 1; bus_size = 2'(sz); bus_addr = 8'(a); bus_wdata = d;
    cur_tag = tag;
    step();
  endtask

  task automatic rd(int sz, int a, string tag);
    bus_valid = 1; bus_write = 0; bus_size = 2'(sz); bus_addr = 8'(a);
    cur_tag = tag;
    step();
  endtask

  task automatic lit(string tag, logic [31:0] exp);
    chk(tag, last_rd, exp);
  endtask

  task automatic phy_read(int phy, int r);
    wr(1, 'h20, 32'(16'h2000 | 16'(phy << 8) | 16'(r)), "R7");
    rd(1, 'h20, "R9");
    rd(1, 'h20, "R9");
    rd(1, 'h24, "R7");
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_reg[i] = 0;
    m_reg['h44] = 16'h9F07;
    for (int i = 0; i < 32; i++) m_phy[i] = 0;
    m_phy[1] = 16'h7869; m_phy[2] = 16'h0243; m_phy[3] = 16'h0C54;
    m_pend = 0; m_irq = 0; m_rxc = 0; m_txc = 0; last_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R10 reset state
    chk("R10 irq after reset", {31'd0, irq_o}, 32'd0);
    rd(1, 'h88, "R10"); lit("R10 status-change word", 32'h9F07);
    rd(1, 'h3C, "R10"); lit("R10 status zero", 32'h0);
    rd(1, 'h04, "R10"); lit("R10 ctrl1 zero", 32'h0);

    // R7 R9 R10: PHY bank reads
    wr(1, 'h20, 32'h2101, "R7");
    rd(1, 'h20, "R9"); lit("R9 busy bits on first poll", 32'h6101);
    rd(1, 'h20, "R9"); lit("R9 busy bits gone on second poll", 32'h0101);
    rd(1, 'h24, "R7"); lit("R10 phy reg1 before link", 32'h7869);
    phy_read(1, 2); lit("R10 phy reg2", 32'h0243);
    phy_read(1, 3); lit("R10 phy reg3", 32'h0C54);
    phy_read(3, 2); lit("R7 absent phy reads ones", 32'hFFFF);

    // R8 writes
    wr(1, 'h28, 32'hBEEF, "R8");
    wr(1, 'h20, 32'h4105, "R8");
    phy_read(1, 5); lit("R8 phy write lands", 32'hBEEF);
    wr(1, 'h28, 32'h1234, "R8");
    wr(1, 'h20, 32'h4205, "R8");
    phy_read(1, 5); lit("R8 absent phy write discarded", 32'hBEEF);
    wr(1, 'h28, 32'h5555, "R7");
    wr(1, 'h20, 32'h6105, "R7");
    rd(1, 'h24, "R7"); lit("R7 read wins over write", 32'hBEEF);
    phy_read(1, 5); lit("R7 no write under read priority", 32'hBEEF);

    // R6 R2 R1
    wr(1, 'h04, 32'h0001, "R6");
    rd(1, 'h04, "R6"); lit("R6 soft reset value", 32'h0010);
    wr(1, 'h04, 32'h0ABC, "R6");
    rd(1, 'h04, "R6"); lit("R6 plain store", 32'h0ABC);
    wr(0, 'h05, 32'h12, "R2");
    rd(1, 'h04, "R2"); lit("R2 byte merge high", 32'h12BC);
    wr(0, 'h04, 32'h37, "R2");
    rd(1, 'h04, "R2"); lit("R2 merged byte triggers reset", 32'h0010);
    rd(0, 'h89, "R1"); lit("R1 byte read high", 32'h9F);
    rd(0, 'h88, "R1"); lit("R1 byte read low", 32'h07);

    // R3 R4
    wr(1, 'h3C, 32'hFFFF, "R3");
    rd(1, 'h3C, "R3"); lit("R3 status ignores write", 32'h0);
    rx_evt = 1; step();
    chk("R4 no irq while disabled", {31'd0, irq_o}, 32'd0);
    wr(1, 'h40, 32'h0011, "R4");
    chk("R4 irq on enable write", {31'd0, irq_o}, 32'd1);
    rd(1, 'h3C, "R3"); lit("R3 status returns rx bit", 32'h0001);
    rd(1, 'h3C, "R3"); lit("R3 status cleared by read", 32'h0);
    chk("R4 irq holds after clear", {31'd0, irq_o}, 32'd1);
    wr(1, 'h40, 32'h0011, "R4");
    chk("R4 irq drops on enable write", {31'd0, irq_o}, 32'd0);
    tx_evt = 1; step();
    chk("R4 irq on tx event", {31'd0, irq_o}, 32'd1);
    rd(1, 'h3C, "R3"); lit("R3 tx bit", 32'h0010);

    // R5
    rx_evt = 1; step(); rx_evt = 1; step();
    wr(1, 'h50, 32'h7777, "R5");
    rd(1, 'h50, "R5"); lit("R5 rx count", 32'h3);
    bus_valid = 1; bus_write = 0; bus_size = 1; bus_addr = 'h50; rx_evt = 1;
    cur_tag = "R5"; step(); lit("R5 read-clear returns zero", 32'h0);
    rd(1, 'h50, "R5"); lit("R5 event after clear counts", 32'h1);
    rd(1, 'h5C, "R5"); lit("R5 tx count", 32'h1);

    // R1 doubleword
    wr(2, 'h60, 32'hCAFE1234, "R1");
    rd(1, 'h60, "R1"); lit("R1 dword low word", 32'h1234);
    rd(1, 'h62, "R1"); lit("R1 dword high word", 32'hCAFE);
    rd(2, 'h60, "R1"); lit("R1 dword read", 32'hCAFE1234);

    // R11 link
    while (cyc < LINK + 2) step();
    phy_read(1, 1); lit("R11 link bit set", 32'h786D);

    // mixed traffic against the model
    begin
      int addrs [11] = '{'h04, 'h20, 'h22, 'h24, 'h28, 'h3C, 'h40, 'h50, 'h5C, 'h60, 'h88};
      for (int n = 0; n < 400; n++) begin
        int a, sz;
        logic [31:0] d;
        a  = addrs[$urandom_range(0, 10)];
        sz = $urandom_range(0, 2);
        if (sz == 0) a += $urandom_range(0, 1);
        d = $urandom;
        if (a == 'h20 && sz != 0)
          d[15:0] = {1'b0, 2'($urandom_range(0, 3)), 3'b0, 5'($urandom_range(0, 2)),
                     3'b0, 5'($urandom_range(0, 7))};
        bus_valid = 1; bus_write = 1'($urandom_range(0, 1));
        bus_size = 2'(sz); bus_addr = 8'(a); bus_wdata = d;
        rx_evt = ($urandom_range(0, 3) == 0);
        tx_evt = ($urandom_range(0, 3) == 0);
        cur_tag = "R1 R3 R5 R7 mixed";
        step();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule